// File: doc/BRIEF.md
# UART Receiver with Programmable Multi-Byte Buffer

This block is the receive half of a UART. It oversamples a serial line, takes each bit by a vote over three samples near the bit centre, and gathers whole characters into a small buffer of one to four slots. When the programmed number of characters has arrived it raises a buffer-full flag, and software reads the slots through an indexed read port.

Configuration arrives as plain level inputs: receiver enable, parity check enable, parity sense, 7/8-bit word length and an overrun policy bit. The buffer length has its own load strobe, which takes effect only while the UART mode bit is high. Error conditions (framing, overrun, noise, parity) are held in sticky flags. Each flag, and the buffer-full flag, is cleared by a one-cycle write-one-to-clear mask. The bit rate comes from a divider input.

Top module: `uart_rx_buf`

## Requirements
- R1: The buffer holds lenCode+1 characters (00=1, 01=2, 10=3, 11=4). Characters go into slots in order from slot 0. bufFull rises when the character that fills the last programmed slot completes.
- R2: curLen loads lenCode only on a clock where cfgWrite and uartMode are both 1. At any other time curLen keeps its value. Reset value is 0.
- R3: frameErr is set when the stop bit is voted low. The character is still stored.
- R4: overrun is set when a character completes while bufFull is 1.
- R5: On overrun with lockMode=1 the new character is dropped and the buffer is unchanged. With lockMode=0 it is written at the write pointer, which returns to slot 0 after the last slot and then advances cyclically.
- R6: Each bit lasts 16 ticks. Samples 7, 8 and 9 after the bit start are voted 2-of-3 to give the bit value. Any disagreement among them sets noiseErr.
- R7: Data arrives LSB first. With wordLen8=0 there are 7 data bits and the stored bit 7 is 0. With wordLen8=1 there are 8 data bits.
- R8: With parityEn=1 a parity bit follows the data bits. parityOdd=1 selects odd parity and 0 selects even. A mismatch sets parityErr and the character is still stored.
- R9: A low level on the line that is voted high at the centre of the start bit is discarded. It stores nothing and sets no flag.
- R10: All flags reset to 0 and are sticky. clrMask bit 0 clears bufFull and returns the write pointer to slot 0. Bits 1, 2, 3 and 4 clear frameErr, overrun, noiseErr and parityErr. A set event in the same cycle wins over a clear.
- R11: While rxEnable=0 the line is ignored and no flag or slot changes.
- R12: One oversampling tick occurs every baudDiv+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxLine | input | 1 | Serial receive line, idle high |
| baudDiv | input | 16 | Tick divider: one tick every baudDiv+1 clocks |
| rxEnable | input | 1 | Receiver enable |
| parityEn | input | 1 | Parity bit present and checked |
| parityOdd | input | 1 | 1 = odd parity, 0 = even |
| wordLen8 | input | 1 | 1 = 8 data bits, 0 = 7 |
| lockMode | input | 1 | 1 = drop an overrunning character, 0 = overwrite |
| uartMode | input | 1 | Allows length loads |
| cfgWrite | input | 1 | Length load strobe |
| lenCode | input | 2 | Buffer length minus one |
| clrMask | input | 5 | Write-one-to-clear pulse: full, frame, overrun, noise, parity |
| rdIdx | input | 2 | Buffer slot to read |
| rdData | output | 8 | Contents of slot rdIdx |
| curLen | output | 2 | Length code currently in force |
| bufFull | output | 1 | Programmed number of characters received |
| frameErr | output | 1 | Sticky framing error |
| overrun | output | 1 | Sticky overrun |
| noiseErr | output | 1 | Sticky noise flag |
| parityErr | output | 1 | Sticky parity error |

## Verification
A wrong write pointer or length register shows up as a character in the wrong slot, or as bufFull rising one character early or late. The bench reads every slot in rotation each clock, so the fault is seen within four clocks after the character settles. Faults in sample-point or vote logic corrupt the stored value or flip noiseErr at the stop-bit decision of the very character involved. Faults in the overrun policy show as a slot changing, or failing to change, when the third character lands in a full buffer.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;

  localparam int CLR_FULL   = 0;
  localparam int CLR_FRAME  = 1;
  localparam int CLR_OVR    = 2;
  localparam int CLR_NOISE  = 3;
  localparam int CLR_PARITY = 4;
  localparam int CLR_W      = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rxState_e;

  // strobes from the bit-timing control to the character datapath
  typedef struct packed {
    logic charStart;  // start bit confirmed at its centre
    logic dataBit;    // data bit decided
    logic parBit;     // parity bit decided
    logic stopBit;    // stop bit decided, character complete
    logic noiseHit;   // centre samples disagreed
    logic value;      // voted bit value
  } rxStrobe_t;
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             rxEnable,
  input  logic             parityEn,
  input  logic             wordLen8,
  output rxStrobe_t        strb
);
  localparam int CNT_W = $clog2(OSR);
  localparam int MID   = OSR / 2;

  logic [1:0]       syncQ;
  logic             rxS;
  logic [DIV_W-1:0] preCnt;
  logic             tick;
  logic [CNT_W-1:0] smpCnt;
  logic [1:0]       vote;
  logic [2:0]       bitIdx;
  logic [2:0]       lastBit;
  logic             majority;
  logic             noisy;
  logic             midPt;
  rxState_e         state;

  assign rxS = syncQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxLine};
  end

  assign tick = (preCnt == baudDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + 1'b1;
  end

  assign majority = (vote[0] & vote[1]) | (vote[0] & rxS) | (vote[1] & rxS);
  assign noisy    = !((vote[0] == vote[1]) && (vote[1] == rxS));
  assign midPt    = rxEnable && tick && (state != ST_IDLE) &&
                    (smpCnt == CNT_W'(MID + 1));
  assign lastBit  = wordLen8 ? 3'd7 : 3'd6;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      smpCnt <= '0;
      vote   <= '0;
      bitIdx <= '0;
    end else if (!rxEnable) begin
      state  <= ST_IDLE;
      smpCnt <= '0;
    end else if (tick) begin
      if (state == ST_IDLE) begin
        if (!rxS) begin
          state  <= ST_START;
          smpCnt <= CNT_W'(1);
        end
      end else begin
        smpCnt <= smpCnt + 1'b1;
        if (smpCnt == CNT_W'(MID - 1)) vote[0] <= rxS;
        if (smpCnt == CNT_W'(MID))     vote[1] <= rxS;
        if (midPt && ((state == ST_START && majority) || state == ST_STOP)) begin
          state  <= ST_IDLE;
          smpCnt <= '0;
        end else if (smpCnt == CNT_W'(OSR - 1)) begin
          smpCnt <= '0;
          case (state)
            ST_START: begin
              state  <= ST_DATA;
              bitIdx <= '0;
            end
            ST_DATA: begin
              if (bitIdx == lastBit) state <= parityEn ? ST_PAR : ST_STOP;
              else                   bitIdx <= bitIdx + 1'b1;
            end
            ST_PAR:  state <= ST_STOP;
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    strb           = '0;
    strb.value     = majority;
    strb.noiseHit  = midPt && noisy;
    strb.charStart = midPt && (state == ST_START) && !majority;
    strb.dataBit   = midPt && (state == ST_DATA);
    strb.parBit    = midPt && (state == ST_PAR);
    strb.stopBit   = midPt && (state == ST_STOP);
  end
endmodule

// File: rtl/uart_rx_data.sv
module uart_rx_data
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LEN_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic              parityOdd,
  input  logic              wordLen8,
  input  logic              lockMode,
  input  logic              uartMode,
  input  logic              cfgWrite,
  input  logic [LEN_W-1:0]  lenCode,
  input  logic [CLR_W-1:0]  clrMask,
  input  logic [LEN_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [LEN_W-1:0]  curLen,
  output logic              bufFull,
  output logic              frameErr,
  output logic              overrun,
  output logic              noiseErr,
  output logic              parityErr
);
  logic [DATA_W-1:0] shReg;
  logic              parAcc;
  logic [LEN_W-1:0]  wrPtr;
  logic [LEN_W-1:0]  lenQ;
  logic [DATA_W-1:0] charByte;
  logic              storeEn;
  logic              parMiss;
  logic [DATA_W-1:0] slotQ [DEPTH];

  assign charByte = wordLen8 ? shReg : {1'b0, shReg[DATA_W-1:1]};
  assign storeEn  = strb.stopBit && !(bufFull && lockMode);
  assign parMiss  = strb.parBit && ((parAcc ^ strb.value) != parityOdd);
  assign curLen   = lenQ;
  assign rdData   = slotQ[rdIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      parAcc <= 1'b0;
    end else if (strb.charStart || strb.stopBit) begin
      shReg  <= '0;
      parAcc <= 1'b0;
    end else if (strb.dataBit) begin
      shReg  <= {strb.value, shReg[DATA_W-1:1]};
      parAcc <= parAcc ^ strb.value;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      lenQ <= '0;
    else if (cfgWrite && uartMode)  lenQ <= lenCode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufFull <= 1'b0;
      wrPtr   <= '0;
    end else begin
      if (clrMask[CLR_FULL]) begin
        bufFull <= 1'b0;
        wrPtr   <= '0;
      end
      if (storeEn) begin
        if (wrPtr >= lenQ) begin
          bufFull <= 1'b1;
          wrPtr   <= '0;
        end else begin
          wrPtr <= wrPtr + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  q <= '0;
      else if (storeEn && wrPtr == LEN_W'(g))     q <= charByte;
    end
    assign slotQ[g] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameErr  <= 1'b0;
      overrun   <= 1'b0;
      noiseErr  <= 1'b0;
      parityErr <= 1'b0;
    end else begin
      if (clrMask[CLR_FRAME])  frameErr  <= 1'b0;
      if (clrMask[CLR_OVR])    overrun   <= 1'b0;
      if (clrMask[CLR_NOISE])  noiseErr  <= 1'b0;
      if (clrMask[CLR_PARITY]) parityErr <= 1'b0;
      if (strb.stopBit && !strb.value) frameErr  <= 1'b1;
      if (strb.stopBit && bufFull)     overrun   <= 1'b1;
      if (strb.noiseHit)               noiseErr  <= 1'b1;
      if (parMiss)                     parityErr <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
  import uart_rx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OSR   = 16,
  parameter int DEPTH = 4,
  parameter int LEN_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic              rxEnable,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              wordLen8,
  input  logic              lockMode,
  input  logic              uartMode,
  input  logic              cfgWrite,
  input  logic [LEN_W-1:0]  lenCode,
  input  logic [CLR_W-1:0]  clrMask,
  input  logic [LEN_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [LEN_W-1:0]  curLen,
  output logic              bufFull,
  output logic              frameErr,
  output logic              overrun,
  output logic              noiseErr,
  output logic              parityErr
);
  rxStrobe_t strb;

  uart_rx_ctrl #(.DIV_W(DIV_W), .OSR(OSR)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .baudDiv(baudDiv),
    .rxEnable(rxEnable), .parityEn(parityEn), .wordLen8(wordLen8),
    .strb(strb)
  );

  uart_rx_data #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .parityOdd(parityOdd),
    .wordLen8(wordLen8), .lockMode(lockMode), .uartMode(uartMode),
    .cfgWrite(cfgWrite), .lenCode(lenCode), .clrMask(clrMask),
    .rdIdx(rdIdx), .rdData(rdData), .curLen(curLen), .bufFull(bufFull),
    .frameErr(frameErr), .overrun(overrun), .noiseErr(noiseErr),
    .parityErr(parityErr)
  );
endmodule

// File: rtl/uart_rx_buf_chk.sv
module uart_rx_buf_chk #(
  parameter int LEN_W  = 2,
  parameter int DATA_W = 8,
  parameter int CLR_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              lockMode,
  input logic              uartMode,
  input logic              cfgWrite,
  input logic [LEN_W-1:0]  lenCode,
  input logic [CLR_W-1:0]  clrMask,
  input logic [LEN_W-1:0]  rdIdx,
  input logic [DATA_W-1:0] rdData,
  input logic [LEN_W-1:0]  curLen,
  input logic              bufFull,
  input logic              frameErr,
  input logic              overrun,
  input logic              noiseErr,
  input logic              parityErr
);
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWrite && uartMode) |=> $stable(curLen)); // R2
  AST_LEN_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && uartMode) |=> (curLen == $past(lenCode))); // R2
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(bufFull)); // R4
  AST_LOCK_KEEPS_SLOTS: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && lockMode && !clrMask[0]) |=> ($stable(rdIdx) -> $stable(rdData))); // R5
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !clrMask[0]) |=> bufFull); // R10
  AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !clrMask[1]) |=> frameErr); // R10
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !clrMask[2]) |=> overrun); // R10
  AST_NOISE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (noiseErr && !clrMask[3]) |=> noiseErr); // R10
  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr && !clrMask[4]) |=> parityErr); // R10
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !($rose(bufFull) || $rose(frameErr) || $rose(noiseErr) ||
                    $rose(parityErr) || $rose(overrun))); // R11
endmodule

bind uart_rx_buf uart_rx_buf_chk #(.LEN_W(LEN_W), .DATA_W(uart_rx_pkg::DATA_W),
                                   .CLR_W(uart_rx_pkg::CLR_W)) u_chk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .lockMode(lockMode),
  .uartMode(uartMode), .cfgWrite(cfgWrite), .lenCode(lenCode),
  .clrMask(clrMask), .rdIdx(rdIdx), .rdData(rdData), .curLen(curLen),
  .bufFull(bufFull), .frameErr(frameErr), .overrun(overrun),
  .noiseErr(noiseErr), .parityErr(parityErr)
);

// File: tb/uart_rx_buf_bench.sv
`timescale 1ns/1ps
module uart_rx_buf_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxLine = 1'b1;
  logic [15:0] baudDiv = 16'd1;
  logic        rxEnable = 1'b1;
  logic        parityEn = 1'b0;
  logic        parityOdd = 1'b0;
  logic        wordLen8 = 1'b1;
  logic        lockMode = 1'b0;
  logic        uartMode = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [1:0]  lenCode = 2'd0;
  logic [4:0]  clrMask = 5'd0;
  logic [1:0]  rdIdx = 2'd0;
  logic [7:0]  rdData;
  logic [1:0]  curLen;
  logic        bufFull, frameErr, overrun, noiseErr, parityErr;

  int checks = 0;
  int errors = 0;
  bit cmpOn = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  int mBuf [4];
  int mPtr = 0;
  int mLen = 0;
  bit mFull = 0, mFrm = 0, mOv = 0, mNs = 0, mPar = 0;

  always #2 clk = ~clk;

  uart_rx_buf u_uart_rx_buf (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .baudDiv(baudDiv),
    .rxEnable(rxEnable), .parityEn(parityEn), .parityOdd(parityOdd),
    .wordLen8(wordLen8), .lockMode(lockMode), .uartMode(uartMode),
    .cfgWrite(cfgWrite), .lenCode(lenCode), .clrMask(clrMask),
    .rdIdx(rdIdx), .rdData(rdData), .curLen(curLen), .bufFull(bufFull),
    .frameErr(frameErr), .overrun(overrun), .noiseErr(noiseErr),
    .parityErr(parityErr)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference, sampled between edges
  initial begin
    for (int i = 0; i < 50; i++) mBuf[i % 4] = 0;
    forever begin
      @(posedge clk);
      #1;
      if (cmpOn) begin
        chk("R1 bufFull", bufFull, mFull);
        chk("R3 frameErr", frameErr, mFrm);
        chk("R4 overrun", overrun, mOv);
        chk("R6 noiseErr", noiseErr, mNs);
        chk("R8 parityErr", parityErr, mPar);
        chk("R2 curLen", curLen, mLen);
        chk("R5 rdData slot", rdData, mBuf[rdIdx]);
      end
      rdIdx = rdIdx + 2'd1;
    end
  end

  task automatic hold(logic v, int n);
    rxLine = v;
    repeat (n) @(negedge clk);
  endtask

  // drive one character; glitchBit >= 0 flips the line briefly at that bit's centre
  task automatic sendChar(int data, bit w8, bit pe, bit po, bit badPar,
                          bit badStop, int glitchBit);
    int nb = w8 ? 8 : 7;
    int bitClk = 16 * (int'(baudDiv) + 1);
    bit p = po ^ badPar;
    @(negedge clk);
    hold(1'b0, bitClk);
    for (int i = 0; i < nb; i++) begin
      p = p ^ data[i];
      if (i == glitchBit) begin
        hold(data[i], 18);
        hold(!data[i], 2);
        hold(data[i], bitClk - 20);
      end else begin
        hold(data[i], bitClk);
      end
    end
    if (pe) hold(p, bitClk);
    hold(!badStop, bitClk);
    hold(1'b1, 2 * bitClk);
  endtask

  task automatic modelChar(int data, bit w8, bit pe, bit badPar, bit badStop, bit nz);
    int v = w8 ? (data & 8'hFF) : (data & 8'h7F);
    if (pe && badPar) mPar = 1;
    if (badStop) mFrm = 1;
    if (nz) mNs = 1;
    if (mFull) mOv = 1;
    if (!(mFull && lockMode)) begin
      mBuf[mPtr] = v;
      if (mPtr >= mLen) begin mFull = 1; mPtr = 0; end
      else mPtr++;
    end
  endtask

  task automatic rxChar(int data, bit badPar, bit badStop, int glitchBit);
    cmpOn = 0;
    sendChar(data, wordLen8, parityEn, parityOdd, badPar, badStop, glitchBit);
    modelChar(data, wordLen8, parityEn, badPar, badStop, glitchBit >= 0);
    cmpOn = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic clearFlags(logic [4:0] m);
    cmpOn = 0;
    @(negedge clk);
    clrMask = m;
    @(negedge clk);
    clrMask = 5'd0;
    if (m[0]) begin mFull = 0; mPtr = 0; end
    if (m[1]) mFrm = 0;
    if (m[2]) mOv = 0;
    if (m[3]) mNs = 0;
    if (m[4]) mPar = 0;
    cmpOn = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic writeLen(bit mode, logic [1:0] code);
    cmpOn = 0;
    @(negedge clk);
    uartMode = mode;
    lenCode  = code;
    cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
    if (mode) mLen = code;
    cmpOn = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset values
    chk("R10 reset bufFull", bufFull, 0);
    chk("R10 reset flags", {frameErr, overrun, noiseErr, parityErr}, 0);
    chk("R2 reset curLen", curLen, 0);
    cmpOn = 1;

    // R2: load ignored without uartMode, accepted with it
    writeLen(1'b0, 2'd3);
    chk("R2 ignored length write", curLen, 0);
    writeLen(1'b1, 2'd1);
    chk("R2 accepted length write", curLen, 1);

    // R1: two-slot buffer fills in order
    rxChar(8'hA5, 0, 0, -1);
    chk("R1 not full after first", bufFull, 0);
    rxChar(8'h3C, 0, 0, -1);
    chk("R1 full after second", bufFull, 1);

    // R4 / R5: overrun with lock drops the character
    lockMode = 1'b1;
    rxChar(8'h77, 0, 0, -1);
    chk("R4 overrun set", overrun, 1);
    // R5: overrun with lockMode=0 overwrites slot 0
    lockMode = 1'b0;
    rxChar(8'h11, 0, 0, -1);
    chk("R5 overwrite kept full", bufFull, 1);

    // R10: clear full and overrun, pointer back to slot 0
    clearFlags(5'b00101);
    chk("R10 full cleared", bufFull, 0);
    chk("R10 overrun cleared", overrun, 0);

    // R1: single-slot length
    writeLen(1'b1, 2'd0);
    rxChar(8'h42, 0, 0, -1);
    chk("R1 one-slot full", bufFull, 1);
    clearFlags(5'h1F);

    // R8: even parity good then bad
    parityEn = 1'b1;
    parityOdd = 1'b0;
    rxChar(8'h0F, 0, 0, -1);
    chk("R8 good even parity", parityErr, 0);
    clearFlags(5'h1F);
    rxChar(8'h10, 1, 0, -1);
    chk("R8 bad parity flagged", parityErr, 1);
    clearFlags(5'h1F);

    // R7: 7-bit words, odd parity
    wordLen8 = 1'b0;
    parityOdd = 1'b1;
    rxChar(8'h55, 0, 0, -1);
    chk("R7 odd parity 7-bit", parityErr, 0);
    clearFlags(5'h1F);
    parityEn = 1'b0;
    rxChar(8'hFF, 0, 0, -1);
    rdIdx = 2'd0;
    #0.1;
    chk("R7 seven-bit value", rdData, 8'h7F);
    clearFlags(5'h1F);
    wordLen8 = 1'b1;

    // R3: low stop bit
    rxChar(8'h81, 0, 1, -1);
    chk("R3 framing flagged", frameErr, 1);
    clearFlags(5'h1F);

    // R6: single centre sample disturbed
    rxChar(8'h00, 0, 0, 2);
    chk("R6 noise flagged", noiseErr, 1);
    clearFlags(5'h1F);

    // R9: short low pulse rejected (compare stays on)
    writeLen(1'b1, 2'd3);
    @(negedge clk);
    hold(1'b0, 4);
    hold(1'b1, 96);
    chk("R9 glitch stores nothing", bufFull, 0);
    chk("R9 glitch no flags", {frameErr, noiseErr, parityErr}, 0);

    // R11: receiver disabled, a full character is ignored (compare stays on)
    rxEnable = 1'b0;
    sendChar(8'h00, 1, 0, 0, 0, 1, -1);
    chk("R11 disabled no frame flag", frameErr, 0);
    rxEnable = 1'b1;
    repeat (8) @(negedge clk);

    // R12: slower tick rate
    baudDiv = 16'd3;
    writeLen(1'b1, 2'd0);
    rxChar(8'hC3, 0, 0, -1);
    chk("R12 full at slow rate", bufFull, 1);
    rdIdx = 2'd0;
    #0.1;
    chk("R12 value at slow rate", rdData, 8'hC3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule